// File: doc/BRIEF.md
# Accumulator ALU with Selective Flag Update

This block is a single-cycle arithmetic and logic unit built around a 16-bit accumulator. Each clock, an opcode selects one operation. The operation combines the accumulator with an operand taken from a shared bus, or acts on the accumulator alone. The result is written back to the accumulator at the next rising edge.

Next to the accumulator sits a four-bit flag register: zero, negative, overflow and carry. Each operation changes only the flags it is defined to change. Every other flag keeps its old value, so a condition produced by an arithmetic step survives later logic or move steps. A sequencer outside this block can then test it. Selecting the operand and sequencing the opcodes are the job of surrounding logic.

Top module: `acc_alu`

## Requirements
- R1: While rst_ni is low, the accumulator is 0 and all four flags are 0.
- R2: Opcode 0 (no-op) and every opcode from 11 to 15 leave the accumulator and all flags unchanged.
- R3: Opcode 1 (clear) writes 0 to the accumulator, sets zero to 1 and negative to 0, and leaves overflow and carry unchanged.
- R4: Opcode 2 (move inverted) writes the bitwise inverse of bus_i to the accumulator and changes no flag.
- R5: Opcode 3 (add) writes accumulator + bus_i modulo 2^16. Carry is the carry out of bit 15. Overflow is 1 when both inputs have the same sign and the result sign differs from them.
- R6: Opcode 4 (subtract) writes accumulator - bus_i modulo 2^16. Carry is the carry out of accumulator + ~bus_i + 1, so 1 means no borrow. Overflow is two's-complement signed overflow of the difference.
- R7: Opcodes 5 (AND) and 6 (OR) write the bitwise AND or OR of the accumulator and bus_i. They update only zero and negative and leave overflow and carry unchanged.
- R8: Opcode 7 shifts the accumulator left by one bit with 0 entering bit 0. Carry receives the old bit 15.
- R9: Opcode 8 shifts the accumulator right by one bit with 0 entering bit 15. Carry receives the old bit 0.
- R10: Opcode 9 shifts the accumulator right by one bit, copying the old bit 15 into bit 15. Carry receives the old bit 0.
- R11: Opcode 10 rotates the accumulator left by one bit, so the old bit 15 moves into bit 0. Carry receives the old bit 15.
- R12: Shifts and rotate leave overflow unchanged. For every operation that updates zero and negative, zero is 1 exactly when the new accumulator is all zeros, and negative equals its bit 15.
- R13: The result of an operation and its flags appear on the outputs after the first rising clock edge at which the opcode was presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation select |
| bus_i | input | 16 | Operand from the shared bus |
| ar_o | output | 16 | Accumulator value |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| o_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
The bound checker covers the hold rules on every cycle. It checks that no-op and unused codes freeze all state, and that each class of operation leaves the flags outside its set untouched. It also checks the results of clear and move inverted, and the zero and negative flags against the written accumulator.

Arithmetic results, carry and overflow on the signed and unsigned boundaries, and the bit that each shift or the rotate pushes into carry come only from the bench. The bench's scenarios drive these directed corner cases and a long random opcode stream through a behavioural model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'd0,
    OP_CLR = 4'd1,
    OP_MVN = 4'd2,
    OP_ADD = 4'd3,
    OP_SUB = 4'd4,
    OP_AND = 4'd5,
    OP_ORR = 4'd6,
    OP_LSL = 4'd7,
    OP_LSR = 4'd8,
    OP_ASR = 4'd9,
    OP_ROL = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LSL,
    SH_LSR,
    SH_ASR,
    SH_ROL
  } shift_kind_e;

  // bit order: z n o c
  typedef struct packed {
    logic z;
    logic n;
    logic o;
    logic c;
  } flags_t;

  localparam int FLAG_N = $bits(flags_t);
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   ext;

  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    ext     = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
    sum_o   = ext[WIDTH-1:0];
    carry_o = ext[WIDTH];
    ovf_o   = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  shift_kind_e      kind_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    unique case (kind_i)
      SH_LSL: begin
        res_o  = {a_i[MSB-1:0], 1'b0};
        cout_o = a_i[MSB];
      end
      SH_LSR: begin
        res_o  = {1'b0, a_i[MSB:1]};
        cout_o = a_i[0];
      end
      SH_ASR: begin
        res_o  = {a_i[MSB], a_i[MSB:1]};
        cout_o = a_i[0];
      end
      default: begin
        res_o  = {a_i[MSB-1:0], a_i[MSB]};
        cout_o = a_i[MSB];
      end
    endcase
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  flags_t upd_i,
  input  flags_t nxt_i,
  output flags_t flags_o
);
  logic [FLAG_N-1:0] upd_v, nxt_v, q_v;

  assign upd_v   = upd_i;
  assign nxt_v   = nxt_i;
  assign flags_o = q_v;

  // one enable per flag bit: untouched flags hold
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_v[i] <= 1'b0;
      else if (upd_v[i]) q_v[i] <= nxt_v[i];
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] ar_o,
  output logic             z_o,
  output logic             n_o,
  output logic             o_o,
  output logic             c_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] ar_q, ar_d;
  logic             ar_we;
  logic [WIDTH-1:0] sum;
  logic             sum_c, sum_o;
  logic [WIDTH-1:0] sh_res;
  logic             sh_c;
  shift_kind_e      sh_kind;
  flags_t           upd, nxt, flags_q;

  assign op = alu_op_e'(op_i);

  acc_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i    (ar_q),
    .b_i    (bus_i),
    .sub_i  (op == OP_SUB),
    .sum_o  (sum),
    .carry_o(sum_c),
    .ovf_o  (sum_o)
  );

  always_comb begin
    unique case (op)
      OP_LSR:  sh_kind = SH_LSR;
      OP_ASR:  sh_kind = SH_ASR;
      OP_ROL:  sh_kind = SH_ROL;
      default: sh_kind = SH_LSL;
    endcase
  end

  acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i   (ar_q),
    .kind_i(sh_kind),
    .res_o (sh_res),
    .cout_o(sh_c)
  );

  always_comb begin
    ar_d  = ar_q;
    ar_we = 1'b0;
    upd   = '0;
    case (op)
      OP_CLR: begin ar_d = '0;            ar_we = 1'b1; upd.z = 1'b1; upd.n = 1'b1; end
      OP_MVN: begin ar_d = ~bus_i;        ar_we = 1'b1; end
      OP_ADD,
      OP_SUB: begin ar_d = sum;           ar_we = 1'b1; upd = '1; end
      OP_AND: begin ar_d = ar_q & bus_i;  ar_we = 1'b1; upd.z = 1'b1; upd.n = 1'b1; end
      OP_ORR: begin ar_d = ar_q | bus_i;  ar_we = 1'b1; upd.z = 1'b1; upd.n = 1'b1; end
      OP_LSL,
      OP_LSR,
      OP_ASR,
      OP_ROL: begin
        ar_d  = sh_res;
        ar_we = 1'b1;
        upd.z = 1'b1;
        upd.n = 1'b1;
        upd.c = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    nxt.z = (ar_d == '0);
    nxt.n = ar_d[WIDTH-1];
    nxt.o = sum_o;
    nxt.c = (op == OP_ADD || op == OP_SUB) ? sum_c : sh_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ar_q <= '0;
    else if (ar_we) ar_q <= ar_d;
  end

  acc_alu_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .nxt_i  (nxt),
    .flags_o(flags_q)
  );

  assign ar_o = ar_q;
  assign z_o  = flags_q.z;
  assign n_o  = flags_q.n;
  assign o_o  = flags_q.o;
  assign c_o  = flags_q.c;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] bus_i,
  input logic [WIDTH-1:0] ar_o,
  input logic             z_o,
  input logic             n_o,
  input logic             o_o,
  input logic             c_o
);
  logic is_hold, is_logic, is_shift, sets_zn;

  assign is_hold  = (op_i == OP_NOP) || (op_i > OP_ROL);
  assign is_logic = (op_i == OP_AND) || (op_i == OP_ORR);
  assign is_shift = (op_i >= OP_LSL) && (op_i <= OP_ROL);
  assign sets_zn  = (op_i == OP_CLR) || (op_i == OP_ADD) || (op_i == OP_SUB) || is_logic || is_shift;

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> (ar_o == '0 && !z_o && !n_o && !o_o && !c_o));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_hold |=> ($stable(ar_o) && $stable(z_o) && $stable(n_o) && $stable(o_o) && $stable(c_o)));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CLR |=> (ar_o == '0 && z_o && !n_o && $stable(o_o) && $stable(c_o)));

  p_move_inv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_MVN |=> (ar_o == ~$past(bus_i) && $stable(z_o) && $stable(n_o) && $stable(o_o) && $stable(c_o)));

  p_logic_keeps_oc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_logic |=> ($stable(o_o) && $stable(c_o)));

  p_shift_keeps_o_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_shift |=> $stable(o_o));

  p_zn_track_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sets_zn |=> (z_o == (ar_o == '0) && n_o == ar_o[WIDTH-1]));
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .op_i  (op_i),
  .bus_i (bus_i),
  .ar_o  (ar_o),
  .z_o   (z_o),
  .n_o   (n_o),
  .o_o   (o_o),
  .c_o   (c_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [15:0] bus_i = 16'd0;
  logic [15:0] ar_o;
  logic        z_o, n_o, o_o, c_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural model state
  int m_ar = 0;
  int m_z = 0, m_n = 0, m_o = 0, m_c = 0;
  string m_tag = "R1";

  always #(CLK_P/2) clk_i = ~clk_i;

  acc_alu u_dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op_i),
    .bus_i (bus_i),
    .ar_o  (ar_o),
    .z_o   (z_o),
    .n_o   (n_o),
    .o_o   (o_o),
    .c_o   (c_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk({m_tag, " R13"}, "ar", int'(ar_o), m_ar);
    chk({m_tag, " R12"}, "z", int'(z_o), m_z);
    chk({m_tag, " R12"}, "n", int'(n_o), m_n);
    chk(m_tag, "o", int'(o_o), m_o);
    chk(m_tag, "c", int'(c_o), m_c);
  endtask

  function automatic int sgn(input int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  task automatic model(input int op, input int b);
    int r, s;
    bit zn;
    zn = 1;
    case (op)
      1: begin m_tag = "R3"; m_ar = 0; end
      2: begin m_tag = "R4"; m_ar = (~b) & 'hFFFF; zn = 0; end
      3: begin
        m_tag = "R5";
        r = m_ar + b;
        s = sgn(m_ar) + sgn(b);
        m_c = (r > 'hFFFF) ? 1 : 0;
        m_o = (s > 32767 || s < -32768) ? 1 : 0;
        m_ar = r & 'hFFFF;
      end
      4: begin
        m_tag = "R6";
        r = m_ar + ((~b) & 'hFFFF) + 1;
        s = sgn(m_ar) - sgn(b);
        m_c = (r > 'hFFFF) ? 1 : 0;
        m_o = (s > 32767 || s < -32768) ? 1 : 0;
        m_ar = r & 'hFFFF;
      end
      5: begin m_tag = "R7"; m_ar = m_ar & b; end
      6: begin m_tag = "R7"; m_ar = m_ar | b; end
      7: begin m_tag = "R8"; m_c = m_ar / 32768; m_ar = (m_ar * 2) % 65536; end
      8: begin m_tag = "R9"; m_c = m_ar % 2; m_ar = m_ar / 2; end
      9: begin m_tag = "R10"; m_c = m_ar % 2; m_ar = (m_ar / 2) + ((m_ar >= 32768) ? 32768 : 0); end
      10: begin m_tag = "R11"; r = m_ar / 32768; m_c = r; m_ar = (m_ar * 2) % 65536 + r; end
      default: begin m_tag = "R2"; zn = 0; end
    endcase
    if (zn) begin
      m_z = (m_ar == 0) ? 1 : 0;
      m_n = (m_ar >= 32768) ? 1 : 0;
    end
  endtask

  task automatic step(input int op, input int b);
    @(negedge clk_i);
    compare_all();
    op_i  = op[3:0];
    bus_i = b[15:0];
    model(op, b);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "ar", int'(ar_o), 0);
    chk("R1", "flags", int'({z_o, n_o, o_o, c_o}), 0);
    rst_ni = 1'b1;
    // add boundaries (R5)
    step(4'd3, 'h7FFF);
    step(4'd3, 'h0001);   // 0x8000, O=1
    step(4'd0, 0);        // R2 hold
    step(4'd3, 'h8000);   // 0x0000, C=1 O=1 Z=1
    step(4'd2, 'h0000);   // R4 -> 0xFFFF, flags held
    step(4'd3, 'h0001);   // 0x0000, C=1 O=0
    // subtract boundaries (R6)
    step(4'd4, 'h0001);   // 0xFFFF, borrow -> C=0, N=1
    step(4'd2, 'h7FFF);   // ar=0x8000
    step(4'd4, 'h0001);   // 0x7FFF, O=1 C=1
    step(4'd4, 'h7FFF);   // 0, Z=1 C=1
    step(4'd13, 'h1234);  // unused code holds (R2)
    // logic keeps O/C (R7)
    step(4'd3, 'h7FFF);
    step(4'd3, 'h0001);   // set O=1
    step(4'd5, 'h00F0);
    step(4'd6, 'h8001);
    step(4'd1, 0);        // clear, O/C kept (R3)
    // shifts (R8..R11)
    step(4'd2, 'h7FFE);   // ar=0x8001
    step(4'd9, 0);        // ASR -> 0xC000, C=1
    step(4'd7, 0);        // LSL -> 0x8000, C=1
    step(4'd10, 0);       // ROL -> 0x0001, C=1
    step(4'd8, 0);        // LSR -> 0, C=1, Z=1
    step(4'd10, 0);       // ROL of 0 -> C=0
    step(4'd2, 'h3FFF);   // 0xC000
    step(4'd8, 0);        // LSR -> 0x6000, C=0
    step(4'd15, 'hFFFF);
    // random stream
    for (int i = 0; i < 400; i++) begin
      step(int'($urandom_range(0, 15)), int'($urandom_range(0, 65535)));
    end
    step(0, 0);
    @(negedge clk_i);
    compare_all();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule